// File: doc/BRIEF.md
# Near-Bank Dot-Product Engine with Ping-Pong Operand Files

This block sits beside one memory bank and computes, for every token row held in that bank's slice, the dot product of a key row with a shared query vector. A hub writes the query once, in 16-element chunks, into a local query buffer. It then starts a job by giving the vector length and the number of rows. The engine reads key rows from its local memory port chunk by chunk. It multiplies and accumulates 16 element pairs per cycle. Each finished score goes into an output register that a group reduction stage drains through a valid/ready handshake.

Operands pass through two register files. One file receives the next key row from memory while the other feeds the 16 multiply-accumulate lanes. The two files trade roles at a row boundary, once the fill of the next row and the computation of the current row are both finished. A tile length that is not a positive multiple of 16, that exceeds the buffer capacity, or that comes with a row count of zero is refused.

The controller has five states. IDLE waits for a start and goes to PRIME on a good configuration. PRIME loads the first row with no multiply-accumulate activity and goes to MAC on the swap. MAC computes a row; when the score is ready it goes to HOLD if the output register is still occupied, to SYNC if the fill is unfinished, back to MAC on a swap, or to IDLE after the last row. HOLD waits for the output register to free and then takes the same exits. SYNC waits for the fill to end and then swaps into MAC, or goes to IDLE.

Top module: `gemv_bank_engine`

## Requirements
- R1: After reset `res_valid`, `busy`, `cfg_err` and `mem_rd_en` are all 0.
- R2: A start pulse is refused when `cfg_dim` is 0, is not a multiple of 16, or exceeds 128, or when `cfg_rows` is 0. A refused start sets `cfg_err` to 1, leaves `busy` at 0 and issues no memory read. An accepted start clears `cfg_err`.
- R3: Each score is the sum over all `cfg_dim` elements of key times query, both treated as signed 16-bit values, accumulated at 40 bits. The score is saturated to the signed 32-bit range: 0x7FFFFFFF at the top and 0x80000000 at the bottom.
- R4: With k = `cfg_dim`/16, chunk c of row r is read from address r*k + c, and the data returns on `mem_rd_data` one cycle after `mem_rd_en`. Lane j of a chunk occupies bits [16j+15:16j]. Query chunk c is written with `q_idx` = c. A job makes exactly rows*k reads.
- R5: A job yields exactly one score per row, in row order.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` stays unchanged. No score is lost under backpressure.
- R7: The first row is loaded completely before computation begins. After that, loading and computing overlap. With `res_ready` held at 1, the last score is taken within rows*(k+3)+2k+8 cycles of the start.
- R8: A start pulse while `busy` is 1 is ignored. The running job continues with its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_start | input | 1 | Start pulse for a job |
| cfg_dim | input | 8 | Vector length in elements |
| cfg_rows | input | 8 | Number of token rows |
| cfg_err | output | 1 | Last start was refused |
| busy | output | 1 | Job in progress |
| q_we | input | 1 | Query chunk write strobe |
| q_idx | input | 3 | Query chunk index |
| q_data | input | 256 | Query chunk, 16 lanes of 16 bits |
| mem_rd_en | output | 1 | Local row read request |
| mem_rd_addr | output | 10 | Local chunk address |
| mem_rd_data | input | 256 | Key chunk returned one cycle after the request |
| res_valid | output | 1 | Score available |
| res_ready | input | 1 | Reduction stage takes the score |
| res_data | output | 32 | Saturated score |

## Verification
A wrong file-select state would feed the lanes a row that is half-written or belongs to the neighbour. That shows as a wrong score for the first row of the second tile, within about 2k+4 cycles of the start. A row counter that slips shows at the end of the job as a missing or extra score and a read count other than rows*k. Losing the overlap makes the job take about twice as long, which breaks the cycle bound. A broken hold shows as soon as the bench withholds ready with a score waiting.

// File: rtl/gemv_pkg.sv
package gemv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRIME,
        S_MAC,
        S_HOLD,
        S_SYNC
    } gstate_t;

endpackage

// File: rtl/gemv_fill.sv
module gemv_fill #(
    parameter int CW = 3,
    parameter int NW = 4,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          go,
    input  logic [NW-1:0] nch,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [CW-1:0] wr_idx,
    output logic          busy
);

    logic [AW-1:0] addr;
    logic [NW-1:0] cnt;
    logic          issuing;
    logic          wq;
    logic [CW-1:0] widx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            cnt     <= '0;
            issuing <= 1'b0;
            wq      <= 1'b0;
            widx    <= '0;
        end else begin
            if (init) begin
                addr <= '0;
            end
            if (go) begin
                issuing <= 1'b1;
                cnt     <= '0;
            end else if (issuing) begin
                addr <= addr + AW'(1);
                cnt  <= cnt + NW'(1);
                if (cnt == nch - NW'(1)) begin
                    issuing <= 1'b0;
                end
            end
            wq   <= issuing;
            widx <= cnt[CW-1:0];
        end
    end

    assign rd_en   = issuing;
    assign rd_addr = addr;
    assign wr_en   = wq;
    assign wr_idx  = widx;
    assign busy    = issuing | wq;

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        issuing |-> (cnt < nch)) else $error("fill index past row end"); // R4

endmodule

// File: rtl/gemv_regfile.sv
module gemv_regfile #(
    parameter int VW         = 256,
    parameter int MAX_CHUNKS = 8,
    parameter int CW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wsel,
    input  logic [CW-1:0] widx,
    input  logic [VW-1:0] wdata,
    input  logic          rd_active,
    input  logic          rsel,
    input  logic [CW-1:0] ridx,
    output logic [VW-1:0] rdata
);

    logic [VW-1:0] rd_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [VW-1:0] cells [MAX_CHUNKS];
        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(b))) begin
                cells[widx] <= wdata;
            end
        end
        assign rd_word[b] = cells[ridx];
    end

    assign rdata = rd_word[rsel];

    AST_SWAP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_active) |-> (wsel != rsel)) else $error("fill hit the computing file"); // R7

endmodule

// File: rtl/gemv_mac.sv
module gemv_mac #(
    parameter int LANES = 16,
    parameter int EW    = 16,
    parameter int ACCW  = 40,
    parameter int RESW  = 32,
    parameter int CW    = 3,
    parameter int NW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  take,
    input  logic [NW-1:0]         nch,
    input  logic [LANES*EW-1:0]   kdat,
    input  logic [LANES*EW-1:0]   qdat,
    output logic [CW-1:0]         idx,
    output logic                  run,
    output logic                  rdy,
    output logic [RESW-1:0]       res
);

    logic signed [2*EW-1:0] prod [LANES];
    logic signed [ACCW-1:0] psum;
    logic signed [ACCW-1:0] acc;
    logic [NW-1:0]          cnt;

    localparam logic signed [ACCW-1:0] HI = {{(ACCW-RESW+1){1'b0}}, {(RESW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] LO = {{(ACCW-RESW+1){1'b1}}, {(RESW-1){1'b0}}};

    always_comb begin
        psum = '0;
        for (int l = 0; l < LANES; l++) begin
            prod[l] = $signed(kdat[l*EW +: EW]) * $signed(qdat[l*EW +: EW]);
            psum    = psum + ACCW'(prod[l]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
            run <= 1'b0;
            rdy <= 1'b0;
        end else if (go) begin
            acc <= '0;
            cnt <= '0;
            run <= 1'b1;
            rdy <= 1'b0;
        end else if (run) begin
            acc <= acc + psum;
            cnt <= cnt + NW'(1);
            if (cnt == nch - NW'(1)) begin
                run <= 1'b0;
                rdy <= 1'b1;
            end
        end else if (take) begin
            rdy <= 1'b0;
        end
    end

    always_comb begin
        if (acc > HI) begin
            res = {1'b0, {(RESW-1){1'b1}}};
        end else if (acc < LO) begin
            res = {1'b1, {(RESW-1){1'b0}}};
        end else begin
            res = acc[RESW-1:0];
        end
    end

    assign idx = cnt[CW-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < nch)) else $error("lane index past row end"); // R3

endmodule

// File: rtl/gemv_bank_engine.sv
module gemv_bank_engine
    import gemv_pkg::*;
#(
    parameter int LANES      = 16,
    parameter int EW         = 16,
    parameter int ACCW       = 40,
    parameter int RESW       = 32,
    parameter int MAX_CHUNKS = 8,
    parameter int ROWW       = 8,
    parameter int AW         = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_start,
    input  logic [$clog2(MAX_CHUNKS*LANES+1)-1:0] cfg_dim,
    input  logic [ROWW-1:0]               cfg_rows,
    output logic                          cfg_err,
    output logic                          busy,
    input  logic                          q_we,
    input  logic [$clog2(MAX_CHUNKS)-1:0] q_idx,
    input  logic [LANES*EW-1:0]           q_data,
    output logic                          mem_rd_en,
    output logic [AW-1:0]                 mem_rd_addr,
    input  logic [LANES*EW-1:0]           mem_rd_data,
    output logic                          res_valid,
    input  logic                          res_ready,
    output logic [RESW-1:0]               res_data
);

    localparam int CW = $clog2(MAX_CHUNKS);
    localparam int NW = $clog2(MAX_CHUNKS + 1);
    localparam int VW = LANES * EW;
    localparam int DW = $clog2(MAX_CHUNKS * LANES + 1);
    localparam int LW = $clog2(LANES);

    gstate_t       st, nst;
    logic [NW-1:0] nch;
    logic [ROWW-1:0] mac_left, fill_left;
    logic          fill_sel, comp_sel;
    logic          err_q;
    logic          res_v;
    logic [RESW-1:0] res_d;

    logic          cfg_ok;
    logic          slot_free;
    logic          init, fill_go, mac_go, take, do_launch;
    logic          fill_busy, fill_we;
    logic [CW-1:0] fill_idx;
    logic          mac_run, mac_rdy;
    logic [CW-1:0] mac_idx;
    logic [RESW-1:0] mac_res;
    logic [VW-1:0] kdat;
    logic [VW-1:0] qbuf [MAX_CHUNKS];

    assign cfg_ok = (cfg_rows != '0) && (cfg_dim != '0) &&
                    (cfg_dim[LW-1:0] == '0) &&
                    (cfg_dim <= DW'(MAX_CHUNKS * LANES));
    assign slot_free = !res_v || res_ready;

    always_ff @(posedge clk) begin
        if (q_we) begin
            qbuf[q_idx] <= q_data;
        end
    end

    always_comb begin
        nst       = st;
        init      = 1'b0;
        fill_go   = 1'b0;
        mac_go    = 1'b0;
        take      = 1'b0;
        do_launch = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (cfg_start && cfg_ok) begin
                    init    = 1'b1;
                    fill_go = 1'b1;
                    nst     = S_PRIME;
                end
            end
            S_PRIME: begin
                if (!fill_busy) begin
                    do_launch = 1'b1;
                end
            end
            S_MAC, S_HOLD: begin
                if (mac_rdy) begin
                    if (slot_free) begin
                        take = 1'b1;
                        if (fill_busy) begin
                            nst = S_SYNC;
                        end else if (mac_left == '0) begin
                            nst = S_IDLE;
                        end else begin
                            do_launch = 1'b1;
                        end
                    end else begin
                        nst = S_HOLD;
                    end
                end
            end
            S_SYNC: begin
                if (!fill_busy) begin
                    if (mac_left == '0) begin
                        nst = S_IDLE;
                    end else begin
                        do_launch = 1'b1;
                    end
                end
            end
            default: nst = S_IDLE;
        endcase
        if (do_launch) begin
            mac_go  = 1'b1;
            fill_go = (fill_left != '0);
            nst     = S_MAC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= nst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nch       <= '0;
            mac_left  <= '0;
            fill_left <= '0;
            fill_sel  <= 1'b0;
            comp_sel  <= 1'b0;
            err_q     <= 1'b0;
            res_v     <= 1'b0;
            res_d     <= '0;
        end else begin
            if (st == S_IDLE && cfg_start) begin
                if (cfg_ok) begin
                    nch       <= NW'(cfg_dim >> LW);
                    mac_left  <= cfg_rows;
                    fill_left <= cfg_rows - ROWW'(1);
                    fill_sel  <= 1'b0;
                    err_q     <= 1'b0;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (do_launch) begin
                comp_sel <= fill_sel;
                fill_sel <= ~fill_sel;
                mac_left <= mac_left - ROWW'(1);
                if (fill_left != '0) begin
                    fill_left <= fill_left - ROWW'(1);
                end
            end
            if (take) begin
                res_v <= 1'b1;
                res_d <= mac_res;
            end else if (res_ready) begin
                res_v <= 1'b0;
            end
        end
    end

    gemv_fill #(.CW(CW), .NW(NW), .AW(AW)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init),
        .go      (fill_go),
        .nch     (nch),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_rd_addr),
        .wr_en   (fill_we),
        .wr_idx  (fill_idx),
        .busy    (fill_busy)
    );

    gemv_regfile #(.VW(VW), .MAX_CHUNKS(MAX_CHUNKS), .CW(CW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (fill_we),
        .wsel      (fill_sel),
        .widx      (fill_idx),
        .wdata     (mem_rd_data),
        .rd_active (mac_run),
        .rsel      (comp_sel),
        .ridx      (mac_idx),
        .rdata     (kdat)
    );

    gemv_mac #(.LANES(LANES), .EW(EW), .ACCW(ACCW), .RESW(RESW), .CW(CW), .NW(NW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mac_go),
        .take  (take),
        .nch   (nch),
        .kdat  (kdat),
        .qdat  (qbuf[mac_idx]),
        .idx   (mac_idx),
        .run   (mac_run),
        .rdy   (mac_rdy),
        .res   (mac_res)
    );

    assign busy      = (st != S_IDLE);
    assign cfg_err   = err_q;
    assign res_valid = res_v;
    assign res_data  = res_d;

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data))) else $error("score dropped"); // R6
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !busy) else $error("refused job started"); // R2
    AST_PRIME_NO_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRIME) |-> !mac_run) else $error("lanes active during priming"); // R7
    AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |-> !fill_busy) else $error("fill restarted while busy"); // R4

endmodule

// File: tb/tb_gemv_bank_engine.sv
module tb_gemv_bank_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_start = 1'b0;
    logic [7:0]   cfg_dim = '0;
    logic [7:0]   cfg_rows = '0;
    logic         cfg_err, busy;
    logic         q_we = 1'b0;
    logic [2:0]   q_idx = '0;
    logic [255:0] q_data = '0;
    logic         mem_rd_en;
    logic [9:0]   mem_rd_addr;
    logic [255:0] mem_rd_data = '0;
    logic         res_valid;
    logic         res_ready = 1'b0;
    logic [31:0]  res_data;

    gemv_bank_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_dim(cfg_dim),
        .cfg_rows(cfg_rows), .cfg_err(cfg_err), .busy(busy), .q_we(q_we),
        .q_idx(q_idx), .q_data(q_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    always #10 clk = ~clk;

    logic [255:0] mem [1024];
    logic [255:0] qv [8];
    logic [31:0]  expv [64];
    int total = 0, fails = 0;
    int got = 0, rd_cnt = 0, rmode = 0;
    longint cyc = 0, last_take = 0;
    bit hold_prev = 0;
    logic [31:0] hold_data = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    task automatic chk(bit ok, string msg, longint act, longint ex);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, ex);
        end
    endtask

    function automatic logic [31:0] model(int r, int k);
        longint acc = 0;
        for (int c = 0; c < k; c++)
            for (int l = 0; l < 16; l++)
                acc += longint'($signed(mem[r*k+c][l*16 +: 16])) *
                       longint'($signed(qv[c][l*16 +: 16]));
        if (acc > 64'sd2147483647) return 32'h7fffffff;
        if (acc < -64'sd2147483648) return 32'h80000000;
        return acc[31:0];
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev)
                chk(res_valid && res_data == hold_data, "R6 held score changed",
                    res_data, hold_data);
            res_ready = (rmode == 0) ? 1'b1 : ($urandom % 2 == 0);
            if (res_valid && res_ready) begin
                chk(res_data == expv[got], "R3/R5 score mismatch", res_data, expv[got]);
                got++;
                last_take = cyc;
            end
            hold_prev = res_valid && !res_ready;
            hold_data = res_data;
            if (mem_rd_en) rd_cnt++;
        end
    end

    task automatic load_query(int pat);
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 16; l++)
                qv[c][l*16 +: 16] = (pat == 0) ? 16'($urandom) : 16'h8000;
            @(negedge clk);
            q_we = 1'b1; q_idx = 3'(c); q_data = qv[c];
        end
        @(negedge clk);
        q_we = 1'b0;
    endtask

    task automatic run_job(int dim, int rows, int mode, int fillpat, bit poke);
        int k = dim / 16;
        longint t0;
        for (int a = 0; a < rows * k; a++)
            for (int l = 0; l < 16; l++)
                mem[a][l*16 +: 16] = (fillpat == 0) ? 16'($urandom) :
                                     (fillpat == 1) ? 16'h8000 : 16'h7fff;
        for (int r = 0; r < rows; r++) expv[r] = model(r, k);
        @(negedge clk);
        got = 0; rd_cnt = 0; rmode = mode;
        cfg_dim = 8'(dim); cfg_rows = 8'(rows); cfg_start = 1'b1; t0 = cyc;
        @(negedge clk);
        cfg_start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            cfg_dim = 8'd16; cfg_rows = 8'd3; cfg_start = 1'b1;   // R8
            @(negedge clk);
            cfg_start = 1'b0;
        end
        while (busy || res_valid) @(negedge clk);
        chk(got == rows, "R5 score count", got, rows);
        chk(rd_cnt == rows * k, "R4 read count", rd_cnt, rows * k);
        chk(cfg_err == 1'b0, "R2 accepted start leaves error clear", cfg_err, 0);
        if (poke) chk(got == rows, "R8 start while busy ignored", got, rows);
        if (mode == 0)
            chk((last_take - t0) <= rows * (k + 3) + 2 * k + 8, "R7 overlap bound",
                last_take - t0, rows * (k + 3) + 2 * k + 8);
    endtask

    task automatic bad_job(int dim, int rows);
        @(negedge clk);
        rd_cnt = 0;
        cfg_dim = 8'(dim); cfg_rows = 8'(rows); cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_err == 1'b1, "R2 refused start flags error", cfg_err, 1);
        chk(busy == 1'b0, "R2 refused start stays idle", busy, 0);
        chk(rd_cnt == 0, "R2 refused start reads nothing", rd_cnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!res_valid && !busy && !cfg_err && !mem_rd_en, "R1 reset outputs",
            {res_valid, busy, cfg_err, mem_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        load_query(0);
        run_job(16, 1, 0, 0, 0);
        run_job(128, 10, 0, 0, 0);
        run_job(48, 12, 1, 0, 0);
        bad_job(24, 4);
        bad_job(0, 4);
        bad_job(144, 4);
        bad_job(32, 0);
        run_job(32, 20, 0, 0, 1);
        for (int i = 0; i < 12; i++)
            run_job(16 * (1 + int'($urandom % 8)), 1 + int'($urandom % 20),
                    int'($urandom % 2), 0, 0);
        load_query(1);
        run_job(128, 2, 0, 1, 0);
        chk(expv[0] == 32'h7fffffff, "R3 positive saturation model", expv[0], 32'h7fffffff);
        run_job(128, 2, 1, 2, 0);
        chk(expv[0] == 32'h80000000, "R3 negative saturation model", expv[0], 32'h80000000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule